// File: doc/BRIEF.md
# Two-Wire Bus Event Flag and Status Unit

This unit is the control core of a two-wire serial bus controller. The shifter, the start/stop logic, the arbitration detector and the address matcher each report what they see as single-cycle strobes. For each strobe the unit raises an attention flag, which software can use as an interrupt. It then presents an 8-bit status code that says what happened. While the flag is up, the unit asks the clock logic to keep the serial clock low. This stalls the bus until software has handled the event.

The status output is valid only while the flag is set. At all other times it shows a fixed idle code, 8'hF8. The flag rises on the clock edge after the strobe. The event code reaches the status output one edge later. Software clears the flag by writing a one to it. The clear drops the clock-hold request in the same cycle and returns the status output to the idle code on the next edge. When several strobes arrive together, a fixed priority decides which code is reported.

Top module: `twi_event_status`

## Requirements
- R1: After reset, flagOut is 0, statusOut is 8'hF8 and sclHold is 0.
- R2: A strobe on any bit of evtStrobe while flagOut is 0 sets flagOut at the next clock edge.
- R3: In the first cycle that flagOut is high after an accepted strobe, statusOut reads 8'hF8. From the next cycle on it reads the event code, until the flag is cleared.
- R4: evtStrobe bit positions and their codes are: bit0 bus error 8'h00, bit1 arbitration lost 8'h38, bit2 START sent 8'h08, bit3 repeated START sent 8'h10, bit4 address+R/W sent 8'h18, bit5 data byte sent 8'h28, bit6 data byte received 8'h50, bit7 own address matched 8'h60, bit8 general call matched 8'h70, bit9 STOP or repeated START received while addressed 8'hA0.
- R5: When several strobes arrive together, the lowest bit position wins. Bus error therefore wins over arbitration loss, and arbitration loss wins over all others.
- R6: sclHold is 1 whenever flagOut is 1 and clrWrite is 0, and 0 whenever flagOut is 0.
- R7: flagOut stays at 1 until a cycle with clrWrite high. After that cycle's edge, flagOut is 0 and statusOut is 8'hF8.
- R8: Strobes that arrive while flagOut is 1 and clrWrite is 0 are ignored. flagOut stays 1 and statusOut keeps the earlier code.
- R9: A strobe in the same cycle as clrWrite is accepted. flagOut stays 1, statusOut reads 8'hF8 for one cycle and then shows the new code.
- R10: clrWrite while flagOut is 0 and no strobe is present has no effect. flagOut stays 0 and statusOut stays 8'hF8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| evtStrobe | input | 10 | One-cycle event strobes, positions per R4 |
| clrWrite | input | 1 | Software write of one to the flag (clears it) |
| flagOut | output | 1 | Attention flag, usable as an interrupt |
| statusOut | output | 8 | Status code, or 8'hF8 when no event is pending |
| sclHold | output | 1 | Request to keep the serial clock low |

## Verification
The flag is due one edge after an accepted strobe. The status code is due two edges after it. A clear write drops sclHold in its own cycle, and flag and status follow on the next edge. The bench drives its inputs just after the falling edge. A behavioural model advances on each rising edge. All three outputs are compared against that model at every falling edge, so each result is checked in exactly the cycle it is due and in every cycle around it.

// File: rtl/twi_evt_pkg.sv
package twi_evt_pkg;
  localparam int NumEvt = 10;
  localparam int CodeW = 8;
  localparam logic [CodeW-1:0] CodeIdle = 8'hF8;

  typedef struct packed {
    logic capture;
    logic load;
    logic toIdle;
  } dpCtl_t;

  function automatic logic [CodeW-1:0] codeOf(input int idx);
    case (idx)
      0: codeOf = 8'h00;
      1: codeOf = 8'h38;
      2: codeOf = 8'h08;
      3: codeOf = 8'h10;
      4: codeOf = 8'h18;
      5: codeOf = 8'h28;
      6: codeOf = 8'h50;
      7: codeOf = 8'h60;
      8: codeOf = 8'h70;
      9: codeOf = 8'hA0;
      default: codeOf = CodeIdle;
    endcase
  endfunction
endpackage

// File: rtl/twi_evt_ctrl.sv
module twi_evt_ctrl
  import twi_evt_pkg::*;
#(
  parameter int EvtCnt = NumEvt
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [EvtCnt-1:0] evtStrobe,
  input  logic              clrWrite,
  output logic              flag,
  output logic              sclHold,
  output dpCtl_t            ctl
);
  logic anyEvt;
  logic accept;
  logic loadPend;

  assign anyEvt = |evtStrobe;
  assign accept = anyEvt && (!flag || clrWrite);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flag     <= 1'b0;
      loadPend <= 1'b0;
    end else begin
      loadPend <= accept;
      if (accept)        flag <= 1'b1;
      else if (clrWrite) flag <= 1'b0;
    end
  end

  assign sclHold     = flag && !clrWrite;
  assign ctl.capture = accept;
  assign ctl.toIdle  = accept || clrWrite;
  assign ctl.load    = loadPend && !clrWrite;

  // R7
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (flag && !clrWrite) |=> flag);

  // R10
  idle_stays_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!flag && !anyEvt) |=> !flag);
endmodule

// File: rtl/twi_evt_datapath.sv
module twi_evt_datapath
  import twi_evt_pkg::*;
#(
  parameter int EvtCnt = NumEvt
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [EvtCnt-1:0] evtStrobe,
  input  dpCtl_t            ctl,
  output logic [CodeW-1:0]  statusOut
);
  logic [CodeW-1:0] selCode;
  logic [CodeW-1:0] pendCode;
  logic [CodeW-1:0] statusReg;

  // lowest set position wins: scan from the top so the lowest overwrites last
  always_comb begin
    selCode = CodeIdle;
    for (int i = EvtCnt - 1; i >= 0; i--) begin
      if (evtStrobe[i]) selCode = codeOf(i);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendCode  <= CodeIdle;
      statusReg <= CodeIdle;
    end else begin
      if (ctl.capture) pendCode <= selCode;
      if (ctl.toIdle)      statusReg <= CodeIdle;
      else if (ctl.load)   statusReg <= pendCode;
    end
  end

  assign statusOut = statusReg;

  // R5
  bus_err_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.capture && evtStrobe[0]) |=> (pendCode == 8'h00));
endmodule

// File: rtl/twi_event_status.sv
module twi_event_status
  import twi_evt_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NumEvt-1:0]    evtStrobe,
  input  logic                 clrWrite,
  output logic                 flagOut,
  output logic [CodeW-1:0]     statusOut,
  output logic                 sclHold
);
  dpCtl_t ctl;

  twi_evt_ctrl #(.EvtCnt(NumEvt)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .evtStrobe (evtStrobe),
    .clrWrite  (clrWrite),
    .flag      (flagOut),
    .sclHold   (sclHold),
    .ctl       (ctl)
  );

  twi_evt_datapath #(.EvtCnt(NumEvt)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .evtStrobe (evtStrobe),
    .ctl       (ctl),
    .statusOut (statusOut)
  );

  // R3
  status_needs_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (statusOut != CodeIdle) |-> flagOut);

  // R3
  status_loaded_chk: assert property (@(posedge clk) disable iff (!rstN)
    (flagOut && $past(flagOut) && !$past(clrWrite)) |-> (statusOut != CodeIdle));

  // R6
  hold_with_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (flagOut && !clrWrite) |-> sclHold);

  // R6
  no_hold_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !flagOut |-> !sclHold);
endmodule

// File: tb/twi_event_status_test.sv
module twi_event_status_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [9:0] evtStrobe = '0;
  logic       clrWrite = 1'b0;
  logic       flagOut;
  logic [7:0] statusOut;
  logic       sclHold;

  int total = 0;
  int bad = 0;
  bit done = 0;
  string phase = "R1";

  // behavioural model state
  bit   mFlag = 0;
  int   mStatus = 'hF8;
  int   mPend = 'hF8;
  bit   mLoadNext = 0;
  int   codeTbl[10] = '{'h00, 'h38, 'h08, 'h10, 'h18, 'h28, 'h50, 'h60, 'h70, 'hA0};

  always #4 clk = ~clk;

  twi_event_status uut (
    .clk(clk), .rstN(rstN), .evtStrobe(evtStrobe), .clrWrite(clrWrite),
    .flagOut(flagOut), .statusOut(statusOut), .sclHold(sclHold)
  );

  always @(posedge clk) begin
    if (!rstN) begin
      mFlag = 0; mStatus = 'hF8; mPend = 'hF8; mLoadNext = 0;
    end else if ((evtStrobe != 0) && (!mFlag || clrWrite)) begin
      for (int i = 0; i < 10; i++) begin
        if (evtStrobe[i]) begin mPend = codeTbl[i]; break; end
      end
      mFlag = 1; mStatus = 'hF8; mLoadNext = 1;
    end else if (clrWrite) begin
      mFlag = 0; mStatus = 'hF8; mLoadNext = 0;
    end else if (mLoadNext) begin
      mStatus = mPend; mLoadNext = 0;
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      total++;
      if (flagOut !== mFlag) begin
        bad++;
        $display("FAIL [%s] R2/R7 flagOut=%0b expected=%0b at %0t", phase, flagOut, mFlag, $time);
      end
      total++;
      if (statusOut !== mStatus[7:0]) begin
        bad++;
        $display("FAIL [%s] R3/R4 statusOut=%02h expected=%02h at %0t", phase, statusOut, mStatus[7:0], $time);
      end
      total++;
      if (sclHold !== (mFlag && !clrWrite)) begin
        bad++;
        $display("FAIL [%s] R6 sclHold=%0b expected=%0b at %0t", phase, sclHold, mFlag && !clrWrite, $time);
      end
    end
  end

  task automatic step(input logic [9:0] e, input logic c);
    @(negedge clk);
    #2;
    evtStrobe = e;
    clrWrite = c;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) step('0, 1'b0);
  endtask

  initial begin
    #(8 * 200000);
    bad++;
    $display("FAIL [%s] watchdog expired, actual=running expected=finished", phase);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    phase = "R1";
    repeat (3) @(negedge clk);
    #2 rstN = 1'b1;
    idle(3);

    phase = "R4";
    for (int i = 0; i < 10; i++) begin
      step(10'b1 << i, 1'b0);
      idle(4);
      step('0, 1'b1);
      idle(2);
    end

    phase = "R5";
    step(10'b10_0010_0011, 1'b0); idle(3); step('0, 1'b1); idle(2);
    step(10'b10_0000_0110, 1'b0); idle(3); step('0, 1'b1); idle(2);
    step(10'b00_1000_1000, 1'b0); idle(3); step('0, 1'b1); idle(2);
    step(10'b11_1111_1100, 1'b0); idle(3); step('0, 1'b1); idle(2);

    phase = "R8";
    step(10'b00_0100_0000, 1'b0);
    step(10'b00_0000_0001, 1'b0);
    step(10'b00_0000_0010, 1'b0);
    idle(2);
    step(10'b10_0000_0000, 1'b0);
    idle(2);
    step('0, 1'b1);
    idle(2);

    phase = "R9";
    step(10'b00_0000_0100, 1'b0);
    idle(3);
    step(10'b00_0010_0000, 1'b1);
    idle(3);
    step(10'b00_0000_0001, 1'b1);
    step('0, 1'b1);
    idle(2);

    phase = "R10";
    step('0, 1'b1);
    step('0, 1'b1);
    idle(3);

    phase = "R7";
    step(10'b01_0000_0000, 1'b0);
    idle(20);
    step('0, 1'b1);
    idle(3);

    phase = "R1";
    step(10'b00_0001_0000, 1'b0);
    idle(2);
    #1 rstN = 1'b0;
    idle(2);
    #1 rstN = 1'b1;
    idle(3);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule